// File: doc/BRIEF.md
# I2C Transfer Word Packer

This block converts a sequence of I2C messages into the 32-bit command words used by a byte-slot I2C master engine. Each message starts with a header beat: a 7-bit target address, a read flag, a byte length and a flag marking the final message of the transfer. Write messages are followed by their data bytes on a separate data stream. Read messages take no data. The block inserts zero placeholder bytes for them, and the engine later overwrites these with the bytes it receives.

Every byte is tagged with a 2-bit attribute. The attribute says whether the engine issues a start condition before the byte, simply continues, or issues a stop condition after it. Bytes are packed three per word. The whole transfer is collected in an internal word store, because the capacity check needs the final word count before any word may leave. When the final byte arrives, the block reports the word count and an error flag. If the transfer fits, the block then streams the words out with a valid/ready handshake. If it does not fit, no word is emitted and the block is ready for the next transfer.

Top module: `i2c_word_packer`

## Requirements
- R1: The first byte of every message is `{addr[6:0], rd}` (read gives 1 in bit 0, write gives 0) and carries attribute START, encoded 2'b01.
- R2: The remaining `len` bytes of a message carry attribute CONT, encoded 2'b10. A write message takes them in order from the data stream. A read message emits `len` bytes of 8'h00 and never asserts `dat_ready`.
- R3: Bytes fill each word in arrival order. The first byte goes to bits 31:24, the second to 23:16 and the third to 15:8. Their attributes go to bits 7:6, 5:4 and 3:2 in the same order. Bits 1:0 are always zero.
- R4: A transfer of N bytes (N = sum of len+1 over its messages) produces exactly 1+(N-1)/3 words. Any unused byte slot and attribute field of the last word is zero.
- R5: If the final byte of the transfer would carry CONT, it carries STOP (2'b11) instead. A final byte that is an address byte keeps START.
- R6: If the word count times 4 exceeds the `CAP_BYTES` parameter (default 32), `done_err` is 1 and no word is emitted. A new transfer is then accepted.
- R7: `done` pulses for one cycle in the cycle after the final byte is taken. At that point `done_words` holds the word count and `done_err` holds the capacity result.
- R8: `out_word` and `out_valid` hold steady while `out_ready` is low. `out_last` marks the final word, and `out_valid` falls after that word is taken.
- R9: While words are being emitted, `hdr_ready` and `dat_ready` stay low, so no header or data beat is taken.
- R10: After reset, `out_valid`, `done` and `dat_ready` are low and `hdr_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_valid | input | 1 | Header beat valid |
| hdr_ready | output | 1 | Header beat accepted |
| hdr_addr | input | 7 | Target address |
| hdr_read | input | 1 | 1 for a read message |
| hdr_len | input | LEN_W (8) | Number of bytes after the address byte |
| hdr_last | input | 1 | Final message of the transfer |
| dat_valid | input | 1 | Write data byte valid |
| dat_ready | output | 1 | Write data byte accepted |
| dat_byte | input | 8 | Write data byte |
| out_valid | output | 1 | Command word valid |
| out_ready | input | 1 | Command word accepted |
| out_word | output | 32 | Packed command word |
| out_last | output | 1 | Final word of the transfer |
| done | output | 1 | One-cycle packing-finished pulse |
| done_err | output | 1 | Capacity exceeded for the finished transfer |
| done_words | output | CNT_W (12) | Word count of the finished transfer |

## Verification
The packing is tried with several transfers:
- a single write whose length leaves the last word partly filled;
- a single read, which shows whether placeholders are generated without touching the data stream;
- a zero-length message, whose final address byte must keep START;
- a mixed write/read/write transfer, which shows whether START lands in the middle of a word.

Two long writes probe the capacity limit. One fills the store exactly and must pass; one needs a single word more and must be refused. A transfer after the refusal shows that the block recovers. A stalled output and header/data beats offered during output show whether words are held steady and whether intake stays closed.

// File: rtl/iwp_pkg.sv
package iwp_pkg;

    typedef enum logic [1:0] {
        ATTR_NOP   = 2'b00,
        ATTR_START = 2'b01,
        ATTR_CONT  = 2'b10,
        ATTR_STOP  = 2'b11
    } attr_e;

    typedef enum logic {
        SEQ_HDR  = 1'b0,
        SEQ_BODY = 1'b1
    } seq_e;

    typedef enum logic {
        CTL_COLLECT = 1'b0,
        CTL_DRAIN   = 1'b1
    } ctl_e;

    // Slot 0 sits at the most significant end of both arrays.
    typedef struct packed {
        logic [0:2][7:0] data;
        logic [0:2][1:0] attr;
        logic [1:0]      pad;
    } word_t;

    // The final byte of a transfer turns CONT into STOP; START is kept.
    function automatic attr_e close_attr(attr_e a, logic fin);
        return (fin && (a == ATTR_CONT)) ? ATTR_STOP : a;
    endfunction

    // The last occupied slot of a final word must not ask to continue.
    function automatic logic tail_ok(word_t w);
        logic ok;
        ok = 1'b1;
        for (int s = 0; s < 3; s++) begin
            if (w.attr[s] != 2'b00) ok = (w.attr[s] != 2'b10);
        end
        return ok;
    endfunction

endpackage

// File: rtl/iwp_byte_seq.sv
module iwp_byte_seq
    import iwp_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             collect,
    input  logic             hdr_valid,
    output logic             hdr_ready,
    input  logic [6:0]       hdr_addr,
    input  logic             hdr_read,
    input  logic [LEN_W-1:0] hdr_len,
    input  logic             hdr_last,
    input  logic             dat_valid,
    output logic             dat_ready,
    input  logic [7:0]       dat_byte,
    output logic             b_valid,
    output logic [7:0]       b_data,
    output attr_e            b_attr,
    output logic             b_final
);

    seq_e             state;
    logic [LEN_W-1:0] rem;
    logic             m_rd;
    logic             m_last;

    always_comb begin
        hdr_ready = 1'b0;
        dat_ready = 1'b0;
        b_valid   = 1'b0;
        b_data    = 8'h00;
        b_attr    = ATTR_START;
        b_final   = 1'b0;
        if (state == SEQ_HDR) begin
            hdr_ready = collect;
            b_valid   = collect && hdr_valid;
            b_data    = {hdr_addr, hdr_read};
            b_final   = hdr_last && (hdr_len == '0);
            b_attr    = close_attr(ATTR_START, b_final);
        end else begin
            dat_ready = collect && !m_rd;
            b_valid   = collect && (m_rd || dat_valid);
            b_data    = m_rd ? 8'h00 : dat_byte;
            b_final   = m_last && (rem == LEN_W'(1));
            b_attr    = close_attr(ATTR_CONT, b_final);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SEQ_HDR;
            rem    <= '0;
            m_rd   <= 1'b0;
            m_last <= 1'b0;
        end else if (b_valid) begin
            if (state == SEQ_HDR) begin
                rem    <= hdr_len;
                m_rd   <= hdr_read;
                m_last <= hdr_last;
                if (hdr_len != '0) state <= SEQ_BODY;
            end else begin
                rem <= rem - LEN_W'(1);
                if (rem == LEN_W'(1)) state <= SEQ_HDR;
            end
        end
    end

    AST_READ_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_BODY && m_rd) |-> !dat_ready); // R2

    AST_ADDR_IS_START: assert property (@(posedge clk) disable iff (rst)
        (hdr_valid && hdr_ready) |-> (b_attr == ATTR_START)); // R1

endmodule

// File: rtl/iwp_word_store.sv
module iwp_word_store
    import iwp_pkg::*;
#(
    parameter int CAP_WORDS = 8,
    parameter int CNT_W     = 12,
    parameter int IDX_W     = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             b_valid,
    input  logic [7:0]       b_data,
    input  attr_e            b_attr,
    input  logic [IDX_W-1:0] rd_idx,
    output word_t            rd_word,
    output logic [CNT_W-1:0] xfer_words,
    output logic             xfer_ovf
);

    word_t            mem [CAP_WORDS];
    logic [CNT_W-1:0] nwords;
    logic [1:0]       slot;
    logic [CNT_W-1:0] nwords_inc;
    logic [CNT_W-1:0] wr_idx;
    logic             wr_ok;

    always_comb begin
        nwords_inc = (nwords == '1) ? nwords : nwords + CNT_W'(1);
        wr_idx     = (slot == 2'd0) ? nwords : nwords - CNT_W'(1);
        wr_ok      = wr_idx < CNT_W'(CAP_WORDS);
        xfer_words = (slot == 2'd0) ? nwords_inc : nwords;
        xfer_ovf   = xfer_words > CNT_W'(CAP_WORDS);
        rd_word    = mem[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            nwords <= '0;
            slot   <= 2'd0;
        end else if (b_valid) begin
            if (slot == 2'd0) nwords <= nwords_inc;
            slot <= (slot == 2'd2) ? 2'd0 : slot + 2'd1;
        end
    end

    generate
        for (genvar i = 0; i < CAP_WORDS; i++) begin : g_entry
            always_ff @(posedge clk) begin
                if (rst) begin
                    mem[i] <= '0;
                end else if (b_valid && !clr && wr_ok && (wr_idx == CNT_W'(i))) begin
                    if (slot == 2'd0) begin
                        mem[i]         <= '0;
                        mem[i].data[0] <= b_data;
                        mem[i].attr[0] <= b_attr;
                    end else begin
                        mem[i].data[slot] <= b_data;
                        mem[i].attr[slot] <= b_attr;
                    end
                end
            end
        end
    endgenerate

    AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (rst || clr)
        (b_valid && slot == 2'd2) |=> (slot == 2'd0)); // R3

endmodule

// File: rtl/iwp_drain_ctl.sv
module iwp_drain_ctl
    import iwp_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fin,
    input  logic [CNT_W-1:0] xfer_words,
    input  logic             xfer_ovf,
    input  word_t            rd_word,
    output logic [IDX_W-1:0] rd_idx,
    output logic             collect,
    output logic             clr,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [31:0]      out_word,
    output logic             out_last,
    output logic             done,
    output logic             done_err,
    output logic [CNT_W-1:0] done_words
);

    ctl_e             state;
    logic [IDX_W-1:0] rptr;
    logic [IDX_W-1:0] last_idx;

    always_comb begin
        collect   = (state == CTL_COLLECT);
        out_valid = (state == CTL_DRAIN);
        out_last  = out_valid && (rptr == last_idx);
        out_word  = rd_word;
        rd_idx    = rptr;
        clr       = (fin && xfer_ovf) || (out_valid && out_ready && out_last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= CTL_COLLECT;
            rptr       <= '0;
            last_idx   <= '0;
            done       <= 1'b0;
            done_err   <= 1'b0;
            done_words <= '0;
        end else begin
            done <= 1'b0;
            if (fin) begin
                done       <= 1'b1;
                done_err   <= xfer_ovf;
                done_words <= xfer_words;
                if (!xfer_ovf) begin
                    state    <= CTL_DRAIN;
                    rptr     <= '0;
                    last_idx <= IDX_W'(xfer_words - CNT_W'(1));
                end
            end else if (out_valid && out_ready) begin
                rptr <= rptr + IDX_W'(1);
                if (out_last) state <= CTL_COLLECT;
            end
        end
    end

    AST_NO_WORDS_ON_ERR: assert property (@(posedge clk) disable iff (rst)
        (done && done_err) |-> !out_valid); // R6

    AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word))); // R8

    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> !out_valid); // R8

    AST_TAIL_STOP: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_last) |-> tail_ok(rd_word)); // R5

endmodule

// File: rtl/i2c_word_packer.sv
module i2c_word_packer
    import iwp_pkg::*;
#(
    parameter int CAP_BYTES = 32,
    parameter int LEN_W     = 8,
    parameter int CNT_W     = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hdr_valid,
    output logic             hdr_ready,
    input  logic [6:0]       hdr_addr,
    input  logic             hdr_read,
    input  logic [LEN_W-1:0] hdr_len,
    input  logic             hdr_last,
    input  logic             dat_valid,
    output logic             dat_ready,
    input  logic [7:0]       dat_byte,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [31:0]      out_word,
    output logic             out_last,
    output logic             done,
    output logic             done_err,
    output logic [CNT_W-1:0] done_words
);

    localparam int CAP_WORDS = CAP_BYTES / 4;
    localparam int IDX_W     = (CAP_WORDS > 1) ? $clog2(CAP_WORDS) : 1;

    logic             collect;
    logic             clr;
    logic             b_valid;
    logic [7:0]       b_data;
    attr_e            b_attr;
    logic             b_final;
    logic [IDX_W-1:0] rd_idx;
    word_t            rd_word;
    logic [CNT_W-1:0] xfer_words;
    logic             xfer_ovf;

    iwp_byte_seq #(.LEN_W(LEN_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .collect   (collect),
        .hdr_valid (hdr_valid),
        .hdr_ready (hdr_ready),
        .hdr_addr  (hdr_addr),
        .hdr_read  (hdr_read),
        .hdr_len   (hdr_len),
        .hdr_last  (hdr_last),
        .dat_valid (dat_valid),
        .dat_ready (dat_ready),
        .dat_byte  (dat_byte),
        .b_valid   (b_valid),
        .b_data    (b_data),
        .b_attr    (b_attr),
        .b_final   (b_final)
    );

    iwp_word_store #(.CAP_WORDS(CAP_WORDS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .b_valid    (b_valid),
        .b_data     (b_data),
        .b_attr     (b_attr),
        .rd_idx     (rd_idx),
        .rd_word    (rd_word),
        .xfer_words (xfer_words),
        .xfer_ovf   (xfer_ovf)
    );

    iwp_drain_ctl #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .fin        (b_valid && b_final),
        .xfer_words (xfer_words),
        .xfer_ovf   (xfer_ovf),
        .rd_word    (rd_word),
        .rd_idx     (rd_idx),
        .collect    (collect),
        .clr        (clr),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_word   (out_word),
        .out_last   (out_last),
        .done       (done),
        .done_err   (done_err),
        .done_words (done_words)
    );

    AST_NO_INTAKE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (!hdr_ready && !dat_ready)); // R9

    AST_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_word[1:0] == 2'b00)); // R3

endmodule

// File: tb/tb_i2c_word_packer.sv
module tb_i2c_word_packer;

    logic        clk = 1'b0;
    logic        rst;
    logic        hdr_valid;
    logic        hdr_ready;
    logic [6:0]  hdr_addr;
    logic        hdr_read;
    logic [7:0]  hdr_len;
    logic        hdr_last;
    logic        dat_valid;
    logic        dat_ready;
    logic [7:0]  dat_byte;
    logic        out_valid;
    logic        out_ready;
    logic [31:0] out_word;
    logic        out_last;
    logic        done;
    logic        done_err;
    logic [11:0] done_words;

    always #4 clk = ~clk;

    i2c_word_packer dut (
        .clk(clk), .rst(rst),
        .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_addr(hdr_addr),
        .hdr_read(hdr_read), .hdr_len(hdr_len), .hdr_last(hdr_last),
        .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_byte(dat_byte),
        .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
        .out_last(out_last), .done(done), .done_err(done_err), .done_words(done_words)
    );

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    int         n_msg;
    logic [6:0] m_addr [4];
    logic       m_rd   [4];
    int         m_len  [4];
    logic [7:0] m_dat  [4][32];
    logic [31:0] exp_w [16];
    int          exp_n;
    logic        exp_err;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic build_expect();
        logic [7:0] bb [80];
        logic [1:0] aa [80];
        int n = 0;
        for (int i = 0; i < n_msg; i++) begin
            bb[n] = {m_addr[i], m_rd[i]}; aa[n] = 2'b01; n++;
            for (int j = 0; j < m_len[i]; j++) begin
                bb[n] = m_rd[i] ? 8'h00 : m_dat[i][j]; aa[n] = 2'b10; n++;
            end
        end
        if (aa[n-1] == 2'b10) aa[n-1] = 2'b11;
        exp_n = 1 + (n - 1) / 3;
        exp_err = (exp_n * 4) > 32;
        for (int w = 0; w < 16; w++) exp_w[w] = 32'h0;
        for (int k = 0; k < n; k++) begin
            if (k / 3 < 16) begin
                exp_w[k/3][31 - 8*(k%3) -: 8] = bb[k];
                exp_w[k/3][7 - 2*(k%3) -: 2]  = aa[k];
            end
        end
    endtask

    // Drives every header and data beat; returns at the negedge after the final beat was taken.
    task automatic send_xfer();
        for (int i = 0; i < n_msg; i++) begin
            hdr_addr = m_addr[i]; hdr_read = m_rd[i];
            hdr_len = 8'(m_len[i]); hdr_last = (i == n_msg - 1);
            hdr_valid = 1'b1;
            while (!hdr_ready) @(negedge clk);
            @(negedge clk);
            hdr_valid = 1'b0;
            if (!m_rd[i]) begin
                for (int j = 0; j < m_len[i]; j++) begin
                    dat_byte = m_dat[i][j]; dat_valid = 1'b1;
                    while (!dat_ready) @(negedge clk);
                    @(negedge clk);
                    dat_valid = 1'b0;
                end
            end else begin
                // R2: read placeholders never open the data stream.
                check(dat_ready == 1'b0, "R2 read msg dat_ready", dat_ready, 0);
                while (!hdr_ready && !done) @(negedge clk);
            end
        end
    endtask

    task automatic check_done(input string name);
        check(done == 1'b1, {"R7 done pulse ", name}, done, 1);
        check(done_words == 12'(exp_n), {"R4 word count ", name}, done_words, exp_n);
        check(done_err == exp_err, {"R6 capacity flag ", name}, done_err, exp_err);
    endtask

    task automatic collect_words(input string name, input bit stall);
        int got = 0;
        int k = 0;
        bit held = 0;
        logic [31:0] hold_w;
        while (got < exp_n && k < 100) begin
            out_ready = stall ? ((k % 3) == 2) : 1'b1;
            #1;
            if (held) check(out_valid && out_word == hold_w, {"R8 stalled word stable ", name}, out_word, hold_w);
            held = 0;
            if (out_valid && out_ready) begin
                check(out_word == exp_w[got], {"R3 R5 word ", name}, out_word, exp_w[got]);
                check(out_last == (got == exp_n - 1), {"R8 last flag ", name}, out_last, got == exp_n - 1);
                got++;
            end else if (out_valid) begin
                held = 1; hold_w = out_word;
            end
            k++;
            @(negedge clk);
        end
        out_ready = 1'b0;
        check(got == exp_n, {"R4 words emitted ", name}, got, exp_n);
        check(out_valid == 1'b0, {"R8 valid drops after last ", name}, out_valid, 0);
    endtask

    task automatic run_ok(input string name, input bit stall);
        build_expect();
        send_xfer();
        check_done(name);
        collect_words(name, stall);
    endtask

    task automatic t_reset();
        rst = 1'b1; hdr_valid = 0; dat_valid = 0; out_ready = 0;
        hdr_addr = 0; hdr_read = 0; hdr_len = 0; hdr_last = 0; dat_byte = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 0, "R10 out_valid after reset", out_valid, 0);
        check(done == 0, "R10 done after reset", done, 0);
        check(hdr_ready == 1, "R10 hdr_ready after reset", hdr_ready, 1);
        check(dat_ready == 0, "R10 dat_ready after reset", dat_ready, 0);
    endtask

    task automatic t_single_write();
        n_msg = 1; m_addr[0] = 7'h50; m_rd[0] = 0; m_len[0] = 3;
        m_dat[0][0] = 8'hA1; m_dat[0][1] = 8'hB2; m_dat[0][2] = 8'hC3;
        run_ok("single write R1 R2", 0);
    endtask

    task automatic t_single_read();
        n_msg = 1; m_addr[0] = 7'h3C; m_rd[0] = 1; m_len[0] = 4;
        run_ok("single read R2", 0);
    endtask

    task automatic t_zero_len();
        n_msg = 1; m_addr[0] = 7'h7F; m_rd[0] = 0; m_len[0] = 0;
        run_ok("address only R5", 0);
    endtask

    task automatic t_mixed_intake();
        n_msg = 3;
        m_addr[0] = 7'h21; m_rd[0] = 0; m_len[0] = 1; m_dat[0][0] = 8'hA5;
        m_addr[1] = 7'h48; m_rd[1] = 1; m_len[1] = 2;
        m_addr[2] = 7'h10; m_rd[2] = 0; m_len[2] = 0;
        build_expect();
        send_xfer();
        check_done("mixed");
        // R9: offer beats while words wait; none may be taken.
        hdr_valid = 1; dat_valid = 1; hdr_last = 1; hdr_len = 0;
        #1;
        check(hdr_ready == 0 && dat_ready == 0, "R9 intake closed during output", {hdr_ready, dat_ready}, 0);
        @(negedge clk);
        check(hdr_ready == 0 && dat_ready == 0, "R9 intake still closed", {hdr_ready, dat_ready}, 0);
        hdr_valid = 0; dat_valid = 0;
        collect_words("mixed R1 R9", 1);
    endtask

    task automatic t_read_tail_stall();
        n_msg = 2;
        m_addr[0] = 7'h50; m_rd[0] = 0; m_len[0] = 2; m_dat[0][0] = 8'h01; m_dat[0][1] = 8'h80;
        m_addr[1] = 7'h50; m_rd[1] = 1; m_len[1] = 3;
        run_ok("write then read R8", 1);
    endtask

    task automatic t_exact_fit();
        n_msg = 1; m_addr[0] = 7'h2A; m_rd[0] = 0; m_len[0] = 23;
        for (int j = 0; j < 23; j++) m_dat[0][j] = 8'(j * 7 + 3);
        run_ok("exact capacity R6", 0);
    endtask

    task automatic t_overflow();
        n_msg = 1; m_addr[0] = 7'h2A; m_rd[0] = 0; m_len[0] = 24;
        for (int j = 0; j < 24; j++) m_dat[0][j] = 8'(j + 1);
        build_expect();
        send_xfer();
        check_done("overflow");
        out_ready = 1;
        for (int c = 0; c < 3; c++) begin
            check(out_valid == 0, "R6 no word after overflow", out_valid, 0);
            @(negedge clk);
        end
        out_ready = 0;
        check(hdr_ready == 1, "R6 new transfer accepted", hdr_ready, 1);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_single_write();
        t_single_read();
        t_zero_len();
        t_mixed_intake();
        t_read_tail_stall();
        t_exact_fit();
        t_overflow();
        t_zero_len();
        t_single_write();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule